// File: doc/BRIEF.md
# Paged EEPROM Write Controller

This block sequences writes into a byte-addressed nonvolatile data array. A core reaches it through two write strobes: one loads a small control/status byte, the other writes an array location. Array reads are combinational. Every accepted program operation holds the array for a fixed number of clock cycles, set by a parameter. During that time a busy flag is raised and the core is locked out.

There are two ways to write. In single-byte mode an array write starts programming at once. In row mode the core first arms the block. The first array write after arming fixes the row, which is the upper address bits. Further writes to that row fill eight volatile byte latches. A start command then programs every latched byte of the row in one operation. Writes to any other row are dropped. Disarming before start throws the latches away and leaves the array untouched. A standby bit parks the array: writes are dropped and reads return FFh.

Control byte layout:
- bit 0: enable
- bit 1: busy, read-only
- bit 2: row-mode arm
- bit 3: start
- bits 5:4: reserved test bits, always 0
- bit 6: standby
- bit 7: reads 0

Top module: `nvmw_ctrl`

## Requirements
- R1: After reset the control byte reads 00h, busy is 0, and every array location reads FFh.
- R2: With enable=1, arm=0 and standby=0, an array write sets busy from the next clock edge for exactly PROG_CYCLES cycles. The written byte reads back from the edge at which busy falls.
- R3: An array write made while enable=0 changes no location and does not set busy.
- R4: While busy, control writes are refused and array writes are dropped rather than queued. The operation in progress still completes.
- R5: When not busy and not in standby, array reads return the stored byte combinationally. While busy they return FFh.
- R6: After arm goes 0 to 1, the first accepted array write fixes the row (address bits ADDR_W-1:3) and does not set busy. Later writes to another row are ignored.
- R7: A start write (bit 3) that also writes enable=1 and arm=1, while enable and arm are already 1, sets start and busy. After PROG_CYCLES cycles all latched bytes of the row are programmed together. Bytes of the row that were not written keep their old content.
- R8: A start write is refused when enable or arm is not already 1: start reads 0 and busy stays 0.
- R9: When row programming ends, arm and start clear to 0 and enable stays set.
- R10: Clearing arm before start discards the latched bytes without touching the array. A later re-arm may fix a new row.
- R11: With standby (bit 6) set, array writes are ignored and reads return FFh. After standby is cleared the stored data is intact.
- R12: Control byte read-back uses the bit positions listed above. Bits 7, 5 and 4 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control/status read-back |
| arr_wr | input | 1 | Array write strobe |
| arr_addr | input | ADDR_W | Array byte address (read and write) |
| arr_wdata | input | 8 | Array write data |
| arr_rdata | output | 8 | Array read data, combinational |
| busy | output | 1 | Programming in progress |

## Verification
Control-byte and latch effects are due one clock edge after the strobe. Busy also rises one edge after the accepted write, and stays high for exactly PROG_CYCLES cycles. Programmed data becomes readable at the same edge at which busy falls, and array reads follow the address with no delay.

The bench drives inputs 2 ns after a rising edge. It updates a behavioural model on each rising edge and compares every output at the falling edge. Directed checks read back results only after the strobe's edge, or after busy has been seen low. The length of each busy window is counted in whole cycles.

// File: rtl/nvmw_pkg.sv
package nvmw_pkg;
    localparam int BYTE_W    = 8;
    localparam int ROW_BYTES = 8;
    localparam int SEL_W     = $clog2(ROW_BYTES);

    // control byte bit positions (software visible)
    localparam int BIT_EN    = 0;
    localparam int BIT_BUSY  = 1;
    localparam int BIT_ARM   = 2;
    localparam int BIT_GO    = 3;
    localparam int BIT_SLEEP = 6;

    typedef logic [ROW_BYTES-1:0][BYTE_W-1:0] row_data_t;

    typedef struct packed {
        logic en;
        logic arm;
        logic go;
        logic sleep;
    } csr_t;
endpackage

// File: rtl/nvmw_prog_timer.sv
module nvmw_prog_timer #(
    parameter int PROG_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (load) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(PROG_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.busy && (st_q.cnt == '0);
endmodule

// File: rtl/nvmw_row_latch.sv
module nvmw_row_latch
    import nvmw_pkg::*;
#(
    parameter int ROW_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr,
    input  logic                 single,
    input  logic [ROW_W-1:0]     wr_row,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [ROW_W-1:0]     row_q,
    output logic [ROW_BYTES-1:0] mask_q,
    output row_data_t            data_q
);
    typedef struct packed {
        row_data_t            data;
        logic [ROW_BYTES-1:0] mask;
        logic [ROW_W-1:0]     row;
        logic                 held;
    } lat_t;

    lat_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.mask = '0;
            st_d.held = 1'b0;
        end else if (wr) begin
            if (single) begin
                // single-byte mode: the buffer carries exactly one byte
                st_d.row              = wr_row;
                st_d.mask             = '0;
                st_d.mask[wr_sel]     = 1'b1;
                st_d.data[wr_sel]     = wr_data;
                st_d.held             = 1'b0;
            end else if (!st_q.held || (st_q.row == wr_row)) begin
                st_d.row              = wr_row;
                st_d.held             = 1'b1;
                st_d.mask[wr_sel]     = 1'b1;
                st_d.data[wr_sel]     = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_q  = st_q.row;
    assign mask_q = st_q.mask;
    assign data_q = st_q.data;
endmodule

// File: rtl/nvmw_cell_array.sv
module nvmw_cell_array
    import nvmw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [ADDR_W-SEL_W-1:0] row,
    input  logic [ROW_BYTES-1:0] mask,
    input  row_data_t            data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BYTE_W-1:0]    rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (commit) begin
            for (int i = 0; i < ROW_BYTES; i++) begin
                if (mask[i]) begin
                    mem_d[{row, SEL_W'(i)}] = data[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/nvmw_ctrl.sv
module nvmw_ctrl
    import nvmw_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              arr_wr,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_wdata,
    output logic [7:0]        arr_rdata,
    output logic              busy
);
    localparam int ROW_W = ADDR_W - SEL_W;

    csr_t csr_q, csr_d;

    logic                 tmr_done;
    logic                 tmr_load;
    logic                 arr_ok;
    logic                 byte_go;
    logic                 cfg_ok;
    logic                 start_go;
    logic                 arm_rise;
    logic                 arm_fall;
    logic                 lat_clr;
    logic [ROW_W-1:0]     lat_row;
    logic [ROW_BYTES-1:0] lat_mask;
    row_data_t            lat_data;
    logic [BYTE_W-1:0]    cell_rd;
    logic                 unused_bits;

    assign unused_bits = ^{cfg_wdata[7], cfg_wdata[5:4], cfg_wdata[BIT_BUSY]};

    // acceptance decode
    always_comb begin
        arr_ok   = arr_wr && !busy && csr_q.en && !csr_q.sleep;
        byte_go  = arr_ok && !csr_q.arm;
        cfg_ok   = cfg_wr && !busy;
        start_go = cfg_ok && cfg_wdata[BIT_GO] && cfg_wdata[BIT_EN] &&
                   cfg_wdata[BIT_ARM] && csr_q.en && csr_q.arm;
        arm_rise = cfg_ok &&  cfg_wdata[BIT_ARM] && !csr_q.arm;
        arm_fall = cfg_ok && !cfg_wdata[BIT_ARM] &&  csr_q.arm;
        lat_clr  = tmr_done || arm_rise || arm_fall;
        tmr_load = byte_go || start_go;
    end

    // control register next state
    always_comb begin
        csr_d = csr_q;
        if (cfg_ok) begin
            csr_d.en    = cfg_wdata[BIT_EN];
            csr_d.arm   = cfg_wdata[BIT_ARM];
            csr_d.sleep = cfg_wdata[BIT_SLEEP];
            csr_d.go    = start_go;
        end
        if (tmr_done && csr_q.go) begin
            csr_d.arm = 1'b0;
            csr_d.go  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else begin
            csr_q <= csr_d;
        end
    end

    nvmw_prog_timer #(
        .PROG_CYCLES(PROG_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .busy (busy),
        .done (tmr_done)
    );

    nvmw_row_latch #(
        .ROW_W(ROW_W)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (lat_clr),
        .wr     (arr_ok),
        .single (!csr_q.arm),
        .wr_row (arr_addr[ADDR_W-1:SEL_W]),
        .wr_sel (arr_addr[SEL_W-1:0]),
        .wr_data(arr_wdata),
        .row_q  (lat_row),
        .mask_q (lat_mask),
        .data_q (lat_data)
    );

    nvmw_cell_array #(
        .ADDR_W(ADDR_W)
    ) u_cells (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (tmr_done),
        .row    (lat_row),
        .mask   (lat_mask),
        .data   (lat_data),
        .rd_addr(arr_addr),
        .rd_data(cell_rd)
    );

    always_comb begin
        cfg_rdata            = '0;
        cfg_rdata[BIT_EN]    = csr_q.en;
        cfg_rdata[BIT_BUSY]  = busy;
        cfg_rdata[BIT_ARM]   = csr_q.arm;
        cfg_rdata[BIT_GO]    = csr_q.go;
        cfg_rdata[BIT_SLEEP] = csr_q.sleep;
        arr_rdata            = (busy || csr_q.sleep) ? 8'hFF : cell_rd;
    end
endmodule

// File: rtl/nvmw_ctrl_chk.sv
module nvmw_ctrl_chk #(
    parameter int PROG_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic [7:0] cfg_rdata,
    input logic [7:0] arr_rdata
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else begin
            run_q <= busy ? run_q + 1 : 0;
        end
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < PROG_CYCLES); // R2

    AST_DISABLED_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cfg_rdata[0])); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_rdata[0]) && $stable(cfg_rdata[6])); // R4

    AST_READ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || cfg_rdata[6]) |-> arr_rdata == 8'hFF); // R5

    AST_GO_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[3] |-> cfg_rdata[0] && cfg_rdata[2] && busy); // R7

    AST_GO_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(cfg_rdata[3]) |-> !cfg_rdata[2] && !cfg_rdata[3]); // R9
endmodule

bind nvmw_ctrl nvmw_ctrl_chk #(
    .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .cfg_rdata(cfg_rdata),
    .arr_rdata(arr_rdata)
);

// File: tb/nvmw_ctrl_bench.sv
module nvmw_ctrl_bench;
    localparam int AW = 6;
    localparam int P  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          arr_wr = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [7:0]    arr_wdata = '0;
    logic [7:0]    arr_rdata;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit fin    = 1'b0;

    always #10 clk = ~clk;

    nvmw_ctrl #(.ADDR_W(AW), .PROG_CYCLES(P)) u_nvmw_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata), .busy(busy)
    );

    // behavioural reference model
    logic [7:0] m_mem [64];
    logic [7:0] m_lat [8];
    logic [7:0] m_mask;
    logic [2:0] m_row;
    bit         m_lock, m_en, m_arm, m_go, m_sb;
    int         m_left;

    always @(posedge clk) begin : model
        bit b, dn, acc, cok, stg, rise, fall;
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            m_mask = 0; m_row = 0; m_lock = 0;
            m_en = 0; m_arm = 0; m_go = 0; m_sb = 0; m_left = 0;
        end else begin
            b    = m_left > 0;
            dn   = m_left == 1;
            acc  = arr_wr && !b && m_en && !m_sb;
            cok  = cfg_wr && !b;
            stg  = cok && cfg_wdata[3] && cfg_wdata[0] && cfg_wdata[2] && m_en && m_arm;
            rise = cok && cfg_wdata[2] && !m_arm;
            fall = cok && !cfg_wdata[2] && m_arm;
            if (dn) begin
                for (int i = 0; i < 8; i++)
                    if (m_mask[i]) m_mem[{m_row, 3'(i)}] = m_lat[i];
            end
            if (b) m_left--;
            if (dn || rise || fall) begin
                m_mask = 0; m_lock = 0;
            end else if (acc) begin
                if (!m_arm) begin
                    m_row = arr_addr[5:3]; m_mask = 8'd1 << arr_addr[2:0];
                    m_lat[arr_addr[2:0]] = arr_wdata; m_left = P; m_lock = 0;
                end else if (!m_lock || m_row == arr_addr[5:3]) begin
                    m_lock = 1; m_row = arr_addr[5:3];
                    m_lat[arr_addr[2:0]] = arr_wdata;
                    m_mask[arr_addr[2:0]] = 1'b1;
                end
            end
            if (cok) begin
                m_en = cfg_wdata[0]; m_arm = cfg_wdata[2];
                m_sb = cfg_wdata[6]; m_go = stg;
            end
            if (stg) m_left = P;
            if (dn && m_go) begin m_arm = 0; m_go = 0; end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            check("R2 busy vs model", 32'(busy), 32'(m_left > 0));
            check("R12 cfg vs model", 32'(cfg_rdata),
                  32'({1'b0, m_sb, 2'b00, m_go, m_arm, (m_left > 0), m_en}));
            check("R5 rdata vs model", 32'(arr_rdata),
                  32'(((m_left > 0) || m_sb) ? 8'hFF : m_mem[arr_addr]));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !fin) begin
            fin = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic cfg(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(posedge clk); #2;
        cfg_wr = 1'b0;
    endtask

    task automatic awr(input logic [AW-1:0] a, input logic [7:0] d);
        arr_wr = 1'b1; arr_addr = a; arr_wdata = d;
        @(posedge clk); #2;
        arr_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
        arr_addr = a; #1;
        check(tag, 32'(arr_rdata), 32'(exp));
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            @(posedge clk); #2;
            n++;
        end
    endtask

    initial begin : main
        int n;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 cfg reset", 32'(cfg_rdata), 32'h00);
        check("R1 busy reset", 32'(busy), 32'h0);
        rd("R1 erased", 6'd5, 8'hFF);

        // disabled write
        awr(6'd3, 8'h5A);
        check("R3 no busy when disabled", 32'(busy), 32'h0);
        rd("R3 array unchanged", 6'd3, 8'hFF);

        // byte mode
        cfg(8'h01);
        check("R12 enable bit0", 32'(cfg_rdata), 32'h01);
        awr(6'd3, 8'h5A);
        check("R2 busy after write", 32'(busy), 32'h1);
        rd("R5 FFh while busy", 6'd3, 8'hFF);
        wait_idle(n);
        check("R2 busy length", 32'(n), 32'(P));
        rd("R2 byte programmed", 6'd3, 8'h5A);
        rd("R5 idle read", 6'd2, 8'hFF);

        // busy lockout
        awr(6'd6, 8'h66);
        cfg(8'h00);
        awr(6'd4, 8'h11);
        wait_idle(n);
        check("R4 cfg write refused", 32'(cfg_rdata), 32'h01);
        rd("R4 write dropped", 6'd4, 8'hFF);
        rd("R4 in-progress completed", 6'd6, 8'h66);

        // row mode
        cfg(8'h05);
        check("R12 arm bit2", 32'(cfg_rdata), 32'h05);
        awr(6'h10, 8'hA0);
        awr(6'h12, 8'hA2);
        awr(6'h21, 8'hEE);
        awr(6'h17, 8'hA7);
        check("R6 latching sets no busy", 32'(busy), 32'h0);
        rd("R6 array not yet written", 6'h10, 8'hFF);
        cfg(8'h0D);
        check("R7 start accepted", 32'(cfg_rdata), 32'h0F);
        wait_idle(n);
        check("R7 row commit length", 32'(n), 32'(P));
        check("R9 arm and start cleared", 32'(cfg_rdata), 32'h01);
        rd("R7 byte 0", 6'h10, 8'hA0);
        rd("R7 byte 2", 6'h12, 8'hA2);
        rd("R7 byte 7", 6'h17, 8'hA7);
        rd("R7 untouched byte kept", 6'h11, 8'hFF);
        rd("R6 other row ignored", 6'h21, 8'hFF);

        // refused start
        cfg(8'h09);
        check("R8 start without arm", 32'(cfg_rdata), 32'h01);
        cfg(8'h04);
        cfg(8'h0C);
        check("R8 start without enable", 32'(cfg_rdata), 32'h04);

        // abort then re-arm on another row
        cfg(8'h05);
        awr(6'h30, 8'h33);
        cfg(8'h01);
        cfg(8'h05);
        awr(6'h08, 8'h88);
        cfg(8'h0D);
        wait_idle(n);
        rd("R10 aborted row untouched", 6'h30, 8'hFF);
        rd("R10 new row programmed", 6'h08, 8'h88);
        rd("R10 discarded latch not committed", 6'h0B, 8'hFF);

        // standby
        cfg(8'h41);
        check("R12 standby bit6", 32'(cfg_rdata), 32'h41);
        rd("R11 reads FFh", 6'd3, 8'hFF);
        awr(6'd3, 8'h77);
        check("R11 write ignored", 32'(busy), 32'h0);
        cfg(8'h01);
        rd("R11 data intact", 6'd3, 8'h5A);

        // reserved bits
        cfg(8'hB1);
        check("R12 reserved bits read 0", 32'(cfg_rdata), 32'h01);

        repeat (3) @(posedge clk);
        #2;
        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule